// File: doc/BRIEF.md
# Asymmetric Dual-Issue Pairing Unit

This block is the in-order issue stage ahead of two unequal execution pipes. Decoded instructions are pushed into a small internal queue. Each cycle the unit looks at the two oldest queued instructions and sends them to a primary slot and a secondary slot. The primary slot takes any instruction class. The secondary slot takes only simple integer operations and the floating-point register exchange.

When the two oldest instructions cannot go out together, only the older one issues, to the primary slot. The younger one stays at the head of the queue. On the next cycle it becomes the older member of a new candidate pair, together with the instruction that follows it. Program order is never broken. A stall from the back end freezes issue, and a taken-branch flush empties the queue.

Both slot outputs are registered. An instruction accepted on one clock edge can appear on a slot output at the following edge at the earliest.

Top module: `pairIssueUnit`

## Requirements
- R1: While reset is held, and on the first sample after it, both slot valids are low and pushReady is high.
- R2: When the queue is not empty and neither stall nor flush is asserted, the oldest queued instruction appears on the primary slot after the next clock edge, whatever its class.
- R3: The class tag is 00 complex, 01 simple integer, 10 floating-point exchange, 11 other floating-point. Two instructions pair only if both carry tag 01 or 10. Otherwise the older one issues alone.
- R4: Two instructions do not pair when the older one writes register dst (write flag set) and the younger one does either of these: reads that register through an enabled source field, or also writes it.
- R5: An instruction refused for pairing stays at the head and is issued in the next cycle as the primary member, paired with its successor when the rules allow. The secondary slot never holds an instruction unless the primary slot holds its immediate predecessor.
- R6: After a paired issue the queue head moves on by two entries, after a single issue by one, and after a cycle with no issue by none.
- R7: A cycle with stall asserted (and no flush) issues nothing and leaves the queue contents and order unchanged.
- R8: A cycle with flush asserted issues nothing, empties the queue and discards any push offered in that cycle. Flush takes precedence over stall.
- R9: pushReady is low exactly when DEPTH entries are held. A push offered while pushReady is low is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Taken-branch flush: empty the queue, issue nothing |
| stall | input | 1 | Back-end stall: issue nothing this cycle |
| pushVld | input | 1 | A decoded instruction is offered to the queue |
| pushCls | input | 2 | Class tag of the offered instruction |
| pushWr | input | 1 | Offered instruction writes pushDst |
| pushDst | input | REG_BITS | Destination register index |
| pushRdA | input | 1 | Source A is read |
| pushSrcA | input | REG_BITS | Source A register index |
| pushRdB | input | 1 | Source B is read |
| pushSrcB | input | REG_BITS | Source B register index |
| pushPay | input | PAY_BITS | Opaque remainder of the instruction word |
| pushReady | output | 1 | Queue can accept a push this cycle |
| priVld | output | 1 | Primary slot holds an issued instruction |
| priCls | output | 2 | Class tag on the primary slot |
| priBody | output | BODY_BITS | Register fields and payload on the primary slot |
| secVld | output | 1 | Secondary slot holds an issued instruction |
| secCls | output | 2 | Class tag on the secondary slot |
| secBody | output | BODY_BITS | Register fields and payload on the secondary slot |

## Verification
Some properties can be checked on every cycle. The checker confirms that the secondary slot never fills alone and only ever carries tags 01 or 10, with a 01 or 10 partner in the primary slot. It also confirms that no issued pair has a register conflict, and that a stalled or flushed cycle is followed by empty slots. Other behaviour needs whole sequences and the bench's reference queue. This covers a refused instruction reappearing as the older member of the next pair, the head moving on by the right count, pushes being dropped when the queue is full or flushed, and the order of payloads kept across long random runs.

// File: rtl/pairPkg.sv
package pairPkg;
  parameter int REG_BITS = 5;
  parameter int PAY_BITS = 16;

  typedef enum logic [1:0] {
    CLS_CPLX = 2'b00,
    CLS_INT  = 2'b01,
    CLS_FXCH = 2'b10,
    CLS_FP   = 2'b11
  } cls_e;

  typedef struct packed {
    logic                wr;
    logic [REG_BITS-1:0] dst;
    logic                rdA;
    logic [REG_BITS-1:0] srcA;
    logic                rdB;
    logic [REG_BITS-1:0] srcB;
  } regs_t;

  typedef struct packed {
    regs_t               regs;
    logic [PAY_BITS-1:0] pay;
  } body_t;

  typedef struct packed {
    cls_e  cls;
    body_t body;
  } instr_t;

  // control -> datapath strobes
  typedef struct packed {
    logic issuePri;
    logic issueSec;
    logic clear;
  } strobe_t;

  localparam int BODY_BITS = $bits(body_t);

  // classes the secondary pipe can execute
  function automatic logic slotBCapable(input cls_e c);
    return (c == CLS_INT) || (c == CLS_FXCH);
  endfunction
endpackage

// File: rtl/pairRules.sv
module pairRules
  import pairPkg::*;
(
  input  cls_e                olderCls,
  input  logic                olderWr,
  input  logic [REG_BITS-1:0] olderDst,
  input  cls_e                youngerCls,
  input  regs_t               youngerRegs,
  output logic                canPair
);
  logic classOk;
  logic readClash;
  logic writeClash;

  always_comb begin
    classOk    = slotBCapable(olderCls) && slotBCapable(youngerCls);
    readClash  = (youngerRegs.rdA && (youngerRegs.srcA == olderDst)) ||
                 (youngerRegs.rdB && (youngerRegs.srcB == olderDst));
    writeClash = youngerRegs.wr && (youngerRegs.dst == olderDst);
    canPair    = classOk && !(olderWr && (readClash || writeClash));
  end
endmodule

// File: rtl/pairControl.sv
module pairControl
  import pairPkg::*;
(
  input  logic                stall,
  input  logic                flush,
  input  logic                head0Vld,
  input  logic                head1Vld,
  input  cls_e                head0Cls,
  input  logic                head0Wr,
  input  logic [REG_BITS-1:0] head0Dst,
  input  cls_e                head1Cls,
  input  regs_t               head1Regs,
  output strobe_t             strb
);
  logic canPair;

  pairRules uRules (
    .olderCls   (head0Cls),
    .olderWr    (head0Wr),
    .olderDst   (head0Dst),
    .youngerCls (head1Cls),
    .youngerRegs(head1Regs),
    .canPair    (canPair)
  );

  always_comb begin
    strb.clear    = flush;
    strb.issuePri = !flush && !stall && head0Vld;
    strb.issueSec = strb.issuePri && head1Vld && canPair;
  end
endmodule

// File: rtl/pairDatapath.sv
module pairDatapath
  import pairPkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic                pushVld,
  input  instr_t              pushEntry,
  output logic                pushReady,
  output logic                head0Vld,
  output logic                head1Vld,
  output cls_e                head0Cls,
  output logic                head0Wr,
  output logic [REG_BITS-1:0] head0Dst,
  output cls_e                head1Cls,
  output regs_t               head1Regs,
  output logic                priVldQ,
  output instr_t              priQ,
  output logic                secVldQ,
  output instr_t              secQ
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  instr_t           mem [DEPTH];
  logic [PTR_W-1:0] rdPtr;
  logic [PTR_W-1:0] rdPtrNext1;
  logic [PTR_W-1:0] wrPtr;
  logic [CNT_W-1:0] count;
  logic [1:0]       popN;
  logic             pushFire;
  instr_t           head0;
  instr_t           head1;

  function automatic logic [PTR_W-1:0] ptrStep(input logic [PTR_W-1:0] p,
                                               input logic [1:0] n);
    int s;
    s = int'(p) + int'(n);
    if (s >= DEPTH) s = s - DEPTH;
    return PTR_W'(s);
  endfunction

  always_comb begin
    pushReady  = (count != CNT_W'(DEPTH));
    pushFire   = pushVld && pushReady && !strb.clear;
    popN       = strb.issueSec ? 2'd2 : (strb.issuePri ? 2'd1 : 2'd0);
    rdPtrNext1 = ptrStep(rdPtr, 2'd1);
    head0      = mem[rdPtr];
    head1      = mem[rdPtrNext1];
    head0Vld   = (count != '0);
    head1Vld   = (count > CNT_W'(1));
    head0Cls   = head0.cls;
    head0Wr    = head0.body.regs.wr;
    head0Dst   = head0.body.regs.dst;
    head1Cls   = head1.cls;
    head1Regs  = head1.body.regs;
  end

  // queue storage
  always_ff @(posedge clk) begin
    if (pushFire) mem[wrPtr] <= pushEntry;
  end

  // queue pointers and occupancy
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else if (strb.clear) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      rdPtr <= ptrStep(rdPtr, popN);
      if (pushFire) wrPtr <= ptrStep(wrPtr, 2'd1);
      count <= count + CNT_W'(pushFire) - CNT_W'(popN);
    end
  end

  // issue slot registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      priVldQ <= 1'b0;
      secVldQ <= 1'b0;
      priQ    <= '0;
      secQ    <= '0;
    end else begin
      priVldQ <= strb.issuePri;
      secVldQ <= strb.issueSec;
      if (strb.issuePri) priQ <= head0;
      if (strb.issueSec) secQ <= head1;
    end
  end
endmodule

// File: rtl/pairIssueUnit.sv
module pairIssueUnit
  import pairPkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 flush,
  input  logic                 stall,
  input  logic                 pushVld,
  input  logic [1:0]           pushCls,
  input  logic                 pushWr,
  input  logic [REG_BITS-1:0]  pushDst,
  input  logic                 pushRdA,
  input  logic [REG_BITS-1:0]  pushSrcA,
  input  logic                 pushRdB,
  input  logic [REG_BITS-1:0]  pushSrcB,
  input  logic [PAY_BITS-1:0]  pushPay,
  output logic                 pushReady,
  output logic                 priVld,
  output logic [1:0]           priCls,
  output logic [BODY_BITS-1:0] priBody,
  output logic                 secVld,
  output logic [1:0]           secCls,
  output logic [BODY_BITS-1:0] secBody
);
  strobe_t             strb;
  instr_t              pushEntry;
  instr_t              priQ;
  instr_t              secQ;
  logic                head0Vld;
  logic                head1Vld;
  cls_e                head0Cls;
  logic                head0Wr;
  logic [REG_BITS-1:0] head0Dst;
  cls_e                head1Cls;
  regs_t               head1Regs;

  always_comb begin
    pushEntry.cls            = cls_e'(pushCls);
    pushEntry.body.regs.wr   = pushWr;
    pushEntry.body.regs.dst  = pushDst;
    pushEntry.body.regs.rdA  = pushRdA;
    pushEntry.body.regs.srcA = pushSrcA;
    pushEntry.body.regs.rdB  = pushRdB;
    pushEntry.body.regs.srcB = pushSrcB;
    pushEntry.body.pay       = pushPay;
    priCls  = priQ.cls;
    priBody = priQ.body;
    secCls  = secQ.cls;
    secBody = secQ.body;
  end

  pairControl uCtrl (
    .stall    (stall),
    .flush    (flush),
    .head0Vld (head0Vld),
    .head1Vld (head1Vld),
    .head0Cls (head0Cls),
    .head0Wr  (head0Wr),
    .head0Dst (head0Dst),
    .head1Cls (head1Cls),
    .head1Regs(head1Regs),
    .strb     (strb)
  );

  pairDatapath #(.DEPTH(DEPTH)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .pushVld  (pushVld),
    .pushEntry(pushEntry),
    .pushReady(pushReady),
    .head0Vld (head0Vld),
    .head1Vld (head1Vld),
    .head0Cls (head0Cls),
    .head0Wr  (head0Wr),
    .head0Dst (head0Dst),
    .head1Cls (head1Cls),
    .head1Regs(head1Regs),
    .priVldQ  (priVld),
    .priQ     (priQ),
    .secVldQ  (secVld),
    .secQ     (secQ)
  );
endmodule

// File: rtl/pairChecker.sv
module pairChecker
  import pairPkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                stall,
  input logic                flush,
  input logic                pushReady,
  input logic                priVld,
  input logic [1:0]          priCls,
  input logic                priWr,
  input logic [REG_BITS-1:0] priDst,
  input logic                secVld,
  input logic [1:0]          secCls,
  input regs_t               secRegs
);
  // R5: the younger slot never issues without its older partner
  assert_sec_with_pri_R5: assert property (@(posedge clk) disable iff (!rstN)
    secVld |-> priVld);

  // R3: secondary slot carries only tag 01 or 10
  assert_sec_class_R3: assert property (@(posedge clk) disable iff (!rstN)
    secVld |-> (secCls == 2'b01 || secCls == 2'b10));

  // R3: the partner of a pair is simple as well
  assert_pri_class_paired_R3: assert property (@(posedge clk) disable iff (!rstN)
    secVld |-> (priCls == 2'b01 || priCls == 2'b10));

  // R4: an issued pair carries no register conflict
  assert_no_clash_R4: assert property (@(posedge clk) disable iff (!rstN)
    (secVld && priWr) |->
      !((secRegs.rdA && secRegs.srcA == priDst) ||
        (secRegs.rdB && secRegs.srcB == priDst) ||
        (secRegs.wr  && secRegs.dst  == priDst)));

  // R7: a stalled cycle issues nothing
  assert_stall_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(stall) |-> (!priVld && !secVld));

  // R8: a flushed cycle issues nothing and frees the queue
  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(flush) |-> (!priVld && !secVld && pushReady));
endmodule

bind pairIssueUnit pairChecker uChk (
  .clk      (clk),
  .rstN     (rstN),
  .stall    (stall),
  .flush    (flush),
  .pushReady(pushReady),
  .priVld   (priVld),
  .priCls   (priCls),
  .priWr    (priQ.body.regs.wr),
  .priDst   (priQ.body.regs.dst),
  .secVld   (secVld),
  .secCls   (secCls),
  .secRegs  (secQ.body.regs)
);

// File: tb/sim_pairIssueUnit.sv
`timescale 1ns/1ps
module sim_pairIssueUnit;
  import pairPkg::*;

  localparam int DEPTH = 8;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 flush = 1'b0;
  logic                 stall = 1'b0;
  logic                 pushVld = 1'b0;
  logic [1:0]           pushCls = '0;
  logic                 pushWr = 1'b0;
  logic [REG_BITS-1:0]  pushDst = '0;
  logic                 pushRdA = 1'b0;
  logic [REG_BITS-1:0]  pushSrcA = '0;
  logic                 pushRdB = 1'b0;
  logic [REG_BITS-1:0]  pushSrcB = '0;
  logic [PAY_BITS-1:0]  pushPay = '0;
  logic                 pushReady;
  logic                 priVld;
  logic [1:0]           priCls;
  logic [BODY_BITS-1:0] priBody;
  logic                 secVld;
  logic [1:0]           secCls;
  logic [BODY_BITS-1:0] secBody;

  pairIssueUnit #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .flush(flush), .stall(stall),
    .pushVld(pushVld), .pushCls(pushCls), .pushWr(pushWr), .pushDst(pushDst),
    .pushRdA(pushRdA), .pushSrcA(pushSrcA), .pushRdB(pushRdB), .pushSrcB(pushSrcB),
    .pushPay(pushPay), .pushReady(pushReady),
    .priVld(priVld), .priCls(priCls), .priBody(priBody),
    .secVld(secVld), .secCls(secCls), .secBody(secBody)
  );

  always #2 clk = ~clk;

  instr_t              refQ[$];
  int                  vecs = 0;
  int                  bad = 0;
  logic [PAY_BITS-1:0] nextId = 1;
  bit                  prevRefused = 0;
  bit                  done = 0;

  function automatic bit refSimple(input cls_e c);
    return (c == CLS_INT) || (c == CLS_FXCH);
  endfunction

  function automatic bit refClash(input instr_t o, input instr_t y);
    if (!o.body.regs.wr) return 0;
    if (y.body.regs.wr && y.body.regs.dst == o.body.regs.dst) return 1;
    if (y.body.regs.rdA && y.body.regs.srcA == o.body.regs.dst) return 1;
    if (y.body.regs.rdB && y.body.regs.srcB == o.body.regs.dst) return 1;
    return 0;
  endfunction

  // one cycle: drive at negedge, model the edge, compare at next negedge
  task automatic step(input bit pv, input int cls, input bit wr, input int dst,
                      input bit ra, input int sa, input bit rb, input int sb,
                      input bit st, input bit fl);
    instr_t ni;
    instr_t eP;
    instr_t eS;
    bit     expP, expS, expReady, rdy, refusedNow;
    string  tag;
    ni.cls            = cls_e'(cls[1:0]);
    ni.body.regs.wr   = wr;
    ni.body.regs.dst  = REG_BITS'(dst);
    ni.body.regs.rdA  = ra;
    ni.body.regs.srcA = REG_BITS'(sa);
    ni.body.regs.rdB  = rb;
    ni.body.regs.srcB = REG_BITS'(sb);
    ni.body.pay       = nextId;
    pushVld = pv; pushCls = cls[1:0]; pushWr = wr; pushDst = ni.body.regs.dst;
    pushRdA = ra; pushSrcA = ni.body.regs.srcA; pushRdB = rb;
    pushSrcB = ni.body.regs.srcB; pushPay = nextId; stall = st; flush = fl;
    #0.5;
    rdy = pushReady;
    expReady = (refQ.size() < DEPTH);
    expP = 0; expS = 0; eP = '0; eS = '0; refusedNow = 0; tag = "R2";
    if (fl) begin
      refQ.delete();
      tag = "R8";
      prevRefused = 0;
    end else begin
      if (!st && refQ.size() >= 1) begin
        expP = 1; eP = refQ[0];
        if (refQ.size() >= 2 && refSimple(refQ[0].cls) && refSimple(refQ[1].cls)
            && !refClash(refQ[0], refQ[1])) begin
          expS = 1; eS = refQ[1];
        end
        refusedNow = (refQ.size() >= 2) && !expS;
      end
      if (st) tag = "R7";
      else if (pv && !expReady) tag = "R9";
      else if (expS && prevRefused) tag = "R5";
      else if (expS) tag = "R6";
      else if (refusedNow && refSimple(refQ[0].cls) && refSimple(refQ[1].cls)) tag = "R4";
      else if (refusedNow) tag = "R3";
      if (!st) prevRefused = refusedNow;
      if (expS) void'(refQ.pop_front());
      if (expP) void'(refQ.pop_front());
      if (pv && expReady) begin
        refQ.push_back(ni);
        nextId = nextId + 1'b1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    vecs++;
    if (priVld !== expP || secVld !== expS || rdy !== expReady ||
        (expP && (priCls !== 2'(eP.cls) || priBody !== eP.body)) ||
        (expS && (secCls !== 2'(eS.cls) || secBody !== eS.body))) begin
      bad++;
      $display("FAIL %s: pri %b %h/%h sec %b %h/%h rdy %b, expected pri %b %h/%h sec %b %h/%h rdy %b",
               tag, priVld, priCls, priBody, secVld, secCls, secBody, rdy,
               expP, 2'(eP.cls), eP.body, expS, 2'(eS.cls), eS.body, expReady);
    end
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  // push while stalled so that entries accumulate
  task automatic hold(input int cls, input bit wr, input int dst,
                      input bit ra, input int sa, input bit rb, input int sb);
    step(1, cls, wr, dst, ra, sa, rb, sb, 1, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7071));
    repeat (3) @(negedge clk);
    // R1: reset state
    vecs++;
    if (priVld !== 1'b0 || secVld !== 1'b0 || pushReady !== 1'b1) begin
      bad++;
      $display("FAIL R1: pri %b sec %b rdy %b, expected 0 0 1", priVld, secVld, pushReady);
    end
    rstN = 1'b1;
    idle();

    // R6: independent simple pair
    hold(1, 1, 1, 0, 0, 0, 0);
    hold(1, 1, 2, 1, 3, 0, 0);
    idle(); idle();

    // R3: complex older refuses pairing, then simple issues alone
    hold(0, 1, 4, 0, 0, 0, 0);
    hold(1, 1, 5, 0, 0, 0, 0);
    idle(); idle(); idle();

    // R3: younger of class 11 refused
    hold(1, 0, 0, 0, 0, 0, 0);
    hold(3, 0, 0, 0, 0, 0, 0);
    idle(); idle(); idle();

    // R3: exchange pairs with exchange
    hold(2, 0, 0, 0, 0, 0, 0);
    hold(2, 0, 0, 0, 0, 0, 0);
    idle(); idle();

    // R4 read-after-write, then R5 held instruction pairs with successor
    hold(1, 1, 6, 0, 0, 0, 0);
    hold(1, 1, 7, 0, 0, 1, 6);
    hold(1, 1, 8, 1, 9, 0, 0);
    idle(); idle(); idle();

    // R4 write-after-write
    hold(1, 1, 10, 0, 0, 0, 0);
    hold(1, 1, 10, 0, 0, 0, 0);
    idle(); idle(); idle();

    // R9: fill past capacity while stalled, then drain
    for (int i = 0; i < DEPTH + 2; i++) hold(1, 1, i, 0, 0, 0, 0);
    for (int i = 0; i < DEPTH; i++) idle();

    // R8: flush with a push offered, under stall as well
    hold(1, 1, 3, 0, 0, 0, 0);
    hold(0, 0, 0, 0, 0, 0, 0);
    step(1, 1, 1, 1, 0, 0, 0, 0, 1, 1);
    idle(); idle();

    // constrained random phase
    for (int n = 0; n < 4000; n++) begin
      step(($urandom_range(0, 9) < 7), $urandom_range(0, 3),
           $urandom_range(0, 1), $urandom_range(0, 3),
           $urandom_range(0, 1), $urandom_range(0, 3),
           $urandom_range(0, 1), $urandom_range(0, 3),
           ($urandom_range(0, 9) == 0), ($urandom_range(0, 39) == 0));
    end
    for (int i = 0; i < DEPTH; i++) idle();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule